// File: doc/BRIEF.md
# Debug System-Speed Access Sequencer

This block sits in the halt-mode debug logic of a processor core and chooses the speed at which each scanned-in debug instruction runs. While the core is halted, the debugger shifts a chain into the instruction path. The chain holds the instruction word plus one extra top bit that requests system-speed execution. An instruction without that bit runs straight away under the debug clock qualifier. An instruction with the bit set is held pending until the restart command is present and the test access port sits in Run-Test/Idle.

When the pending access is launched, the sequencer hands the core over from the debug clock enable to the system clock enable, with one idle cycle in between. It then waits for the memory access to finish, for as many cycles as the system clock enable stalls it. After that it hands the core back through a second idle cycle. On return it raises the debug acknowledge, sets a sticky completion flag in the debug status word, and clears the speed request flag.

Only single and block load/store instructions may carry the speed request. Any other flagged instruction is refused: it runs at debug speed and completion is reported at once.

Top module: `dbg_sysspeed_seq`

## Requirements
- R1: During and after reset the core is in debug state. The debug-enable select is 1, the system-enable select is 0, the acknowledge is 1, the completion flag is 0, the speed flag is 0 and the debug-execute pulse is 0.
- R2: The chain holds the instruction word in bits INSTR_W-1:0 and the speed-request flag in bit INSTR_W. A load with the flag at 0, taken in debug state, gives a one-cycle `exec_dbg` pulse in the following cycle and shows the word on `exec_word`. The core stays on the debug enable.
- R3: A load of a legal instruction with the flag at 1 arms the sequencer. `sys_flag` reads 1 from the next cycle, the acknowledge stays 1 and no debug execution pulse is produced.
- R4: An instruction is legal for system speed when bits 27:26 equal 2'b01 (single transfer) or bits 27:25 equal 3'b100 (block transfer).
- R5: An armed access launches only in a cycle where `restart_cmd` and `tap_rti` are both 1. Either one alone leaves it armed.
- R6: The two enable selects are never both 1. Every switch between them passes through exactly one cycle in which both are 0.
- R7: The acknowledge and the completion flag read 0 from the first idle cycle after launch until the core is back in debug state.
- R8: The access completes in a cycle where the system-enable select, `sys_clken` and `mem_done` are all 1. A stall of any length keeps the system enable selected, with no timeout.
- R9: One idle cycle after completion, the core is back in debug state with acknowledge 1, completion 1 and `sys_flag` 0. Completion then stays 1 through debug-speed loads until the next launch.
- R10: A flagged instruction that is not legal is refused. It gives the `exec_dbg` pulse, sets completion to 1 in the next cycle, leaves `sys_flag` at 0 and causes no switch of enables.
- R11: Chain loads arriving while armed or anywhere in the system-speed sequence are ignored. They change neither `exec_word` nor `exec_dbg`.
- R12: `core_clken` follows `dbg_tcken` while the debug enable is selected, follows `sys_clken` while the system enable is selected, and is 0 in the idle cycles.
- R13: In `dbg_status`, bit 3 is the completion flag, bit 0 is the acknowledge and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_load | input | 1 | Chain contents are presented to the pipeline this cycle |
| scan_chain | input | INSTR_W+1 | Instruction word with the speed-request flag on top |
| restart_cmd | input | 1 | Restart command held in the test port instruction register |
| tap_rti | input | 1 | Test port is in Run-Test/Idle |
| sys_clken | input | 1 | System clock enable, may stall the core |
| dbg_tcken | input | 1 | Debug clock enable derived from the test clock |
| mem_done | input | 1 | Memory access of the system-speed instruction finishes |
| dbg_sel | output | 1 | Core is qualified by the debug enable |
| sys_sel | output | 1 | Core is qualified by the system enable |
| core_clken | output | 1 | Qualified clock enable for the core |
| dbg_ack | output | 1 | Debug acknowledge |
| sys_done | output | 1 | Sticky completion flag |
| sys_flag | output | 1 | Speed-request flag as read back from the chain |
| exec_dbg | output | 1 | One-cycle pulse: instruction executed at debug speed |
| exec_word | output | INSTR_W | Last accepted instruction word |
| dbg_status | output | STAT_W | Debug status word |

## Verification
Some rules are checked by assertions on every cycle:
- the two enable selects stay exclusive, and each switch has its idle cycle;
- acknowledge and completion stay low while the system enable is selected;
- a stalled access never leaves system speed;
- the idle cycles gate the core enable off;
- every return to debug state shows completion high and the speed flag cleared.

Other behaviour depends on a sequence of stimulus, so only the bench scenarios show it:
- legal and illegal instruction classes are told apart;
- launch needs both the restart command and Run-Test/Idle;
- loads are ignored outside debug state;
- completion stays sticky afterwards.

// File: rtl/dbg_sysspeed_pkg.sv
package dbg_sysspeed_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_ARMED  = 3'd1,
        SQ_GAP_UP = 3'd2,
        SQ_SYS    = 3'd3,
        SQ_GAP_DN = 3'd4
    } seq_state_e;

    localparam logic [1:0] CLS_SINGLE = 2'b01;
    localparam logic [2:0] CLS_BLOCK  = 3'b100;

endpackage

// File: rtl/dbg_ldst_class.sv
module dbg_ldst_class
    import dbg_sysspeed_pkg::*;
(
    input  logic [2:0] cls_field,
    output logic       is_ldst
);

    logic single_xfer;
    logic block_xfer;

    always_comb begin
        single_xfer = (cls_field[2:1] == CLS_SINGLE);
        block_xfer  = (cls_field == CLS_BLOCK);
        is_ldst     = single_xfer | block_xfer;
    end

endmodule

// File: rtl/dbg_clken_mux.sv
module dbg_clken_mux (
    input  logic dbg_sel,
    input  logic sys_sel,
    input  logic dbg_tcken,
    input  logic sys_clken,
    output logic core_clken
);

    always_comb begin
        core_clken = (dbg_sel & dbg_tcken) | (sys_sel & sys_clken);
    end

endmodule

// File: rtl/dbg_speed_fsm.sv
module dbg_speed_fsm
    import dbg_sysspeed_pkg::*;
#(
    parameter int INSTR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_valid,
    input  logic               ld_flag,
    input  logic               ld_legal,
    input  logic [INSTR_W-1:0] ld_word,
    input  logic               restart_cmd,
    input  logic               tap_rti,
    input  logic               sys_clken,
    input  logic               mem_done,
    output logic               dbg_sel,
    output logic               sys_sel,
    output logic               sys_done,
    output logic               sys_flag,
    output logic               exec_dbg,
    output logic [INSTR_W-1:0] exec_word
);

    typedef struct packed {
        seq_state_e         state;
        logic               flag;
        logic               done;
        logic               exec;
        logic [INSTR_W-1:0] word;
    } seq_regs_t;

    localparam seq_regs_t RESET_VAL = '{
        state: SQ_IDLE,
        flag:  1'b0,
        done:  1'b0,
        exec:  1'b0,
        word:  '0
    };

    seq_regs_t r_d;
    seq_regs_t r_q;

    always_comb begin
        r_d      = r_q;
        r_d.exec = 1'b0;
        unique case (r_q.state)
            SQ_IDLE: begin
                if (ld_valid) begin
                    r_d.word = ld_word;
                    if (ld_flag && ld_legal) begin
                        r_d.state = SQ_ARMED;
                        r_d.flag  = 1'b1;
                    end else begin
                        r_d.exec = 1'b1;
                        if (ld_flag) begin
                            r_d.done = 1'b1;
                        end
                    end
                end
            end
            SQ_ARMED: begin
                if (restart_cmd && tap_rti) begin
                    r_d.state = SQ_GAP_UP;
                    r_d.done  = 1'b0;
                end
            end
            SQ_GAP_UP: begin
                r_d.state = SQ_SYS;
            end
            SQ_SYS: begin
                if (sys_clken && mem_done) begin
                    r_d.state = SQ_GAP_DN;
                end
            end
            SQ_GAP_DN: begin
                r_d.state = SQ_IDLE;
                r_d.done  = 1'b1;
                r_d.flag  = 1'b0;
            end
            default: begin
                r_d = RESET_VAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= RESET_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        dbg_sel   = (r_q.state == SQ_IDLE) || (r_q.state == SQ_ARMED);
        sys_sel   = (r_q.state == SQ_SYS);
        sys_done  = r_q.done;
        sys_flag  = r_q.flag;
        exec_dbg  = r_q.exec;
        exec_word = r_q.word;
    end

endmodule

// File: rtl/dbg_sysspeed_seq.sv
module dbg_sysspeed_seq
    import dbg_sysspeed_pkg::*;
#(
    parameter int INSTR_W  = 32,
    parameter int CLS_HI   = 27,
    parameter int STAT_W   = 4,
    parameter int DONE_BIT = 3,
    parameter int ACK_BIT  = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_load,
    input  logic [INSTR_W:0]   scan_chain,
    input  logic               restart_cmd,
    input  logic               tap_rti,
    input  logic               sys_clken,
    input  logic               dbg_tcken,
    input  logic               mem_done,
    output logic               dbg_sel,
    output logic               sys_sel,
    output logic               core_clken,
    output logic               dbg_ack,
    output logic               sys_done,
    output logic               sys_flag,
    output logic               exec_dbg,
    output logic [INSTR_W-1:0] exec_word,
    output logic [STAT_W-1:0]  dbg_status
);

    localparam int FLAG_POS = INSTR_W;
    localparam int CLS_LO   = CLS_HI - 2;

    logic legal;

    dbg_ldst_class u_class (
        .cls_field (scan_chain[CLS_HI:CLS_LO]),
        .is_ldst   (legal)
    );

    dbg_speed_fsm #(
        .INSTR_W (INSTR_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ld_valid    (scan_load),
        .ld_flag     (scan_chain[FLAG_POS]),
        .ld_legal    (legal),
        .ld_word     (scan_chain[INSTR_W-1:0]),
        .restart_cmd (restart_cmd),
        .tap_rti     (tap_rti),
        .sys_clken   (sys_clken),
        .mem_done    (mem_done),
        .dbg_sel     (dbg_sel),
        .sys_sel     (sys_sel),
        .sys_done    (sys_done),
        .sys_flag    (sys_flag),
        .exec_dbg    (exec_dbg),
        .exec_word   (exec_word)
    );

    dbg_clken_mux u_mux (
        .dbg_sel    (dbg_sel),
        .sys_sel    (sys_sel),
        .dbg_tcken  (dbg_tcken),
        .sys_clken  (sys_clken),
        .core_clken (core_clken)
    );

    assign dbg_ack = dbg_sel;

    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        if (i == DONE_BIT) begin : g_done
            assign dbg_status[i] = sys_done;
        end else if (i == ACK_BIT) begin : g_ack
            assign dbg_status[i] = dbg_ack;
        end else begin : g_zero
            assign dbg_status[i] = 1'b0;
        end
    end

endmodule

// File: rtl/dbg_sysspeed_chk.sv
module dbg_sysspeed_chk (
    input logic clk,
    input logic rst_n,
    input logic dbg_sel,
    input logic sys_sel,
    input logic core_clken,
    input logic dbg_ack,
    input logic sys_done,
    input logic sys_flag,
    input logic sys_clken,
    input logic mem_done
);

    // R6: never both enables selected
    p_one_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sys_sel, dbg_sel}));

    // R6: idle cycle before entering system speed
    p_gap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_sel) |-> !$past(dbg_sel));

    // R6: idle cycle before returning to debug speed
    p_gap_dn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_sel) |-> !$past(sys_sel));

    // R7: acknowledge and completion low during system speed
    p_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_sel |-> (!dbg_ack && !sys_done));

    // R8: a stalled access keeps the system enable
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_sel && !(sys_clken && mem_done)) |=> sys_sel);

    // R9: return to debug state reports completion and clears the flag
    p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dbg_ack) |-> (sys_done && !sys_flag));

    // R12: no core enable in idle cycles
    p_gap_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_sel && !dbg_sel) |-> !core_clken);

endmodule

bind dbg_sysspeed_seq dbg_sysspeed_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_sel    (dbg_sel),
    .sys_sel    (sys_sel),
    .core_clken (core_clken),
    .dbg_ack    (dbg_ack),
    .sys_done   (sys_done),
    .sys_flag   (sys_flag),
    .sys_clken  (sys_clken),
    .mem_done   (mem_done)
);

// File: tb/dbg_sysspeed_seq_bench.sv
module dbg_sysspeed_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 32;
    localparam int WATCHDOG   = 5000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_load = 1'b0;
    logic [W:0]   scan_chain = '0;
    logic         restart_cmd = 1'b0;
    logic         tap_rti = 1'b0;
    logic         sys_clken = 1'b0;
    logic         dbg_tcken = 1'b0;
    logic         mem_done = 1'b0;
    logic         dbg_sel, sys_sel, core_clken, dbg_ack, sys_done, sys_flag, exec_dbg;
    logic [W-1:0] exec_word;
    logic [3:0]   dbg_status;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur = "R1";

    // reference model: phase 0 idle, 1 armed, 2 gap up, 3 system, 4 gap down
    int           m_ph = 0;
    bit           m_flag = 0, m_done = 0, m_exec = 0;
    logic [W-1:0] m_word = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dbg_sysspeed_seq u_dbg_sysspeed_seq (
        .clk(clk), .rst_n(rst_n), .scan_load(scan_load), .scan_chain(scan_chain),
        .restart_cmd(restart_cmd), .tap_rti(tap_rti), .sys_clken(sys_clken),
        .dbg_tcken(dbg_tcken), .mem_done(mem_done), .dbg_sel(dbg_sel),
        .sys_sel(sys_sel), .core_clken(core_clken), .dbg_ack(dbg_ack),
        .sys_done(sys_done), .sys_flag(sys_flag), .exec_dbg(exec_dbg),
        .exec_word(exec_word), .dbg_status(dbg_status)
    );

    function automatic bit legal_cls(input logic [W-1:0] w);
        return (w[27:26] == 2'b01) || (w[27:25] == 3'b100);
    endfunction

    task automatic model_step();
        bit fl;
        fl = scan_chain[W];
        m_exec = 0;
        if (!rst_n) begin
            m_ph = 0; m_flag = 0; m_done = 0; m_word = '0;
        end else if (m_ph == 0) begin
            if (scan_load) begin
                m_word = scan_chain[W-1:0];
                if (fl && legal_cls(scan_chain[W-1:0])) begin
                    m_ph = 1; m_flag = 1;
                end else begin
                    m_exec = 1;
                    if (fl) m_done = 1;
                end
            end
        end else if (m_ph == 1) begin
            if (restart_cmd && tap_rti) begin
                m_ph = 2; m_done = 0;
            end
        end else if (m_ph == 2) begin
            m_ph = 3;
        end else if (m_ph == 3) begin
            if (sys_clken && mem_done) m_ph = 4;
        end else begin
            m_ph = 0; m_done = 1; m_flag = 0;
        end
    endtask

    task automatic chk(input string req, input string name, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) %s actual %0h expected %0h at cycle %0d",
                     req, cur, name, act, exp, cycles);
        end
    endtask

    task automatic compare();
        bit e_dbg, e_sys, e_clk;
        e_dbg = (m_ph <= 1);
        e_sys = (m_ph == 3);
        e_clk = e_dbg ? dbg_tcken : (e_sys ? sys_clken : 1'b0);
        chk("R6", "dbg_sel", 64'(dbg_sel), 64'(e_dbg));
        chk("R6", "sys_sel", 64'(sys_sel), 64'(e_sys));
        chk("R12", "core_clken", 64'(core_clken), 64'(e_clk));
        chk("R7", "dbg_ack", 64'(dbg_ack), 64'(e_dbg));
        chk("R9", "sys_done", 64'(sys_done), 64'(m_done));
        chk("R3", "sys_flag", 64'(sys_flag), 64'(m_flag));
        chk("R2", "exec_dbg", 64'(exec_dbg), 64'(m_exec));
        chk("R2", "exec_word", 64'(exec_word), 64'(m_word));
        chk("R13", "dbg_status", 64'(dbg_status), 64'({m_done, 2'b00, e_dbg}));
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            compare();
            dbg_tcken = ~dbg_tcken;
        end
    endtask

    task automatic load(input bit fl, input logic [W-1:0] w);
        scan_load = 1'b1;
        scan_chain = {fl, w};
        tick();
        scan_load = 1'b0;
    endtask

    task automatic launch();
        restart_cmd = 1'b1; tap_rti = 1'b1;
        tick();
        restart_cmd = 1'b0; tap_rti = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                errors++;
                $display("FAIL watchdog expired after %0d cycles, expected end", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        @(negedge clk);
        cur = "R1";
        tick(3);
        rst_n = 1'b1;
        tick();

        cur = "R2";
        load(1'b0, 32'hE1A0_0000);
        tick(2);

        cur = "R10";
        load(1'b1, 32'hE080_0001);
        tick(2);

        cur = "R4";
        load(1'b1, 32'hE590_1000);
        tick();

        cur = "R11";
        load(1'b0, 32'h1234_5678);
        load(1'b1, 32'hE8BD_000F);
        tick();

        cur = "R5";
        restart_cmd = 1'b1;
        tick(2);
        restart_cmd = 1'b0; tap_rti = 1'b1;
        tick(2);
        tap_rti = 1'b0;
        tick();

        cur = "R8";
        launch();
        mem_done = 1'b1; sys_clken = 1'b0;
        tick(6);
        mem_done = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sys_clken = ~sys_clken;
            tick();
        end
        cur = "R11";
        sys_clken = 1'b0;
        load(1'b0, 32'hAAAA_5555);
        cur = "R8";
        sys_clken = 1'b1; mem_done = 1'b1;
        tick();
        sys_clken = 1'b0; mem_done = 1'b0;
        cur = "R9";
        tick(3);
        load(1'b0, 32'hE1A0_1001);
        tick(2);

        cur = "R4";
        load(1'b1, 32'hE8BD_00F0);
        launch();
        sys_clken = 1'b1; mem_done = 1'b1;
        tick(4);
        sys_clken = 1'b0; mem_done = 1'b0;
        load(1'b1, 32'hE380_0001);
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule